// File: doc/BRIEF.md
# Register-Window CPU Debug Bridge

This block gives a debug host access to the whole register space of a CPU through a small window of 16-bit host registers. It does not map each CPU register into host space. The host first loads a target register number into an address register and, for a write, the two 16-bit halves of the 32-bit value. It then writes a command that starts one read or one write. General-purpose and special-purpose registers share one CPU address space, so both are reached through the same window.

The block turns each command into one request/acknowledge transaction on the CPU's debug port. A three-state machine runs it:

- `ST_IDLE` moves to `ST_WRITE` on a write command, or to `ST_READ` on a read command.
- `ST_WRITE` and `ST_READ` hold the request until the CPU acknowledges, then return to `ST_IDLE`.
- On a read acknowledge, the returned word is latched into the two data halves.

A separate control register drives the CPU's stall and reset lines. When it is read, it reports the CPU's actual stall state.

Top module: `dbgwin_bridge`

## Requirements
- R1: Host registers sit at 0x0200 (target address), 0x0201 (data bits 15:0), 0x0202 (data bits 31:16), 0x0203 (command) and 0x0204 (control). The address and data registers read back what was written. Any other host address reads as 0, and writes to it change nothing.
- R2: After reset, all window registers are 0, `cpu_req`, `cpu_stall` and `cpu_rst` are low, and the command register reads 0.
- R3: A command write with bit 0 = 1 raises `cpu_req` with `cpu_we` = 1 in the next cycle. In that cycle `cpu_addr` equals the address register and `cpu_wdata` equals {data-high, data-low}.
- R4: A command write with bit 1 = 1 and bit 0 = 0 raises `cpu_req` with `cpu_we` = 0 in the next cycle. If both bits are 1, a write is started.
- R5: Command read bit 0 (busy) is 1 from the cycle after the command until the cycle after `cpu_ack`. Until the acknowledge, `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` hold steady.
- R6: When a read is acknowledged, `cpu_rdata[15:0]` goes into data-low and `cpu_rdata[31:16]` into data-high. Both are readable from the next cycle.
- R7: While busy, host writes to the address, data and command registers are ignored.
- R8: Control bit 0 drives `cpu_stall` and control bit 1 drives `cpu_rst`, each for as long as the bit stays set. Control writes are accepted even while busy.
- R9: A control read returns bit 0 = the live `cpu_stalled` input and bit 1 = the written reset bit.
- R10: One command gives exactly one transaction: `cpu_req` is low in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Host write enable (1 = write) |
| host_addr | input | 16 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational from host_addr) |
| cpu_req | output | 1 | Debug-port request |
| cpu_we | output | 1 | Debug-port direction (1 = write) |
| cpu_addr | output | 16 | CPU register address |
| cpu_wdata | output | 32 | CPU write data |
| cpu_rdata | input | 32 | CPU read data, valid with cpu_ack |
| cpu_ack | input | 1 | Debug-port acknowledge |
| cpu_stall | output | 1 | Stall request to the CPU |
| cpu_rst | output | 1 | Reset to the CPU |
| cpu_stalled | input | 1 | CPU reports it is stalled |

## Verification
The hardest case to reach is a host write that arrives while a transaction is outstanding. The bench has to hold `cpu_ack` low for several cycles after a command so that the request stays open. During that gap it writes new address and command values, and then checks that `cpu_addr` and the transaction kind did not change. The read-latch path is reached by presenting `cpu_rdata` only in the acknowledge cycle and removing it afterwards, so the data halves can only hold the value captured on that edge. The stall readback is separated from the stall request by driving `cpu_stalled` opposite to the written control bit.

// File: rtl/dbgwin_pkg.sv
`timescale 1ns/1ps
package dbgwin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } dbg_state_t;

    localparam int OFF_ADDR = 0;
    localparam int OFF_DLO  = 1;
    localparam int OFF_DHI  = 2;
    localparam int OFF_CMD  = 3;
    localparam int OFF_CTRL = 4;
    localparam int NUM_REGS = 5;
endpackage

// File: rtl/dbgwin_fsm.sv
`timescale 1ns/1ps
module dbgwin_fsm
    import dbgwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_rd,
    input  logic cpu_ack,
    output logic cpu_req,
    output logic cpu_we,
    output logic busy,
    output logic rd_load
);
    dbg_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr)      state_d = ST_WRITE;
                else if (start_rd) state_d = ST_READ;
            end
            ST_WRITE: if (cpu_ack) state_d = ST_IDLE;
            ST_READ:  if (cpu_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        rd_load = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WRITE: begin
                cpu_req = 1'b1;
                cpu_we  = 1'b1;
            end
            ST_READ: begin
                cpu_req = 1'b1;
                rd_load = cpu_ack;
            end
            default: ;
        endcase
    end

    assign busy = cpu_req;

    p_start_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !busy) |=> (cpu_req && cpu_we));
    p_start_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rd && !start_wr && !busy) |=> (cpu_req && !cpu_we));
    p_single_txn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack) |=> !cpu_req);
endmodule

// File: rtl/dbgwin_regs.sv
`timescale 1ns/1ps
module dbgwin_regs
    import dbgwin_pkg::*;
#(
    parameter int HAW  = 16,
    parameter int HW   = 16,
    parameter int AW   = 16,
    parameter logic [HAW-1:0] BASE = 16'h0200,
    localparam int DW  = 2 * HW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_sel,
    input  logic           host_we,
    input  logic [HAW-1:0] host_addr,
    input  logic [HW-1:0]  host_wdata,
    output logic [HW-1:0]  host_rdata,
    input  logic           busy,
    input  logic           cpu_stalled,
    input  logic           rd_load,
    input  logic [DW-1:0]  rd_word,
    output logic           start_wr,
    output logic           start_rd,
    output logic [AW-1:0]  addr_o,
    output logic [DW-1:0]  word_o,
    output logic           stall_o,
    output logic           rst_o
);
    logic [HAW-1:0] off;
    logic           in_win;
    logic [NUM_REGS-1:0] wsel;
    logic [AW-1:0]  addr_q;
    logic [HW-1:0]  dlo_q, dhi_q;
    logic           stall_q, crst_q;
    logic [HW-1:0]  addr_ext;

    assign off    = host_addr - BASE;
    assign in_win = (host_addr >= BASE) && (off < HAW'(NUM_REGS));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_wsel
        assign wsel[i] = host_sel && host_we && in_win && (off == HAW'(i));
    end

    assign start_wr = wsel[OFF_CMD] && !busy && host_wdata[0];
    assign start_rd = wsel[OFF_CMD] && !busy && host_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            dlo_q   <= '0;
            dhi_q   <= '0;
            stall_q <= 1'b0;
            crst_q  <= 1'b0;
        end else begin
            if (wsel[OFF_ADDR] && !busy) addr_q <= host_wdata[AW-1:0];
            if (rd_load) begin
                dlo_q <= rd_word[HW-1:0];
                dhi_q <= rd_word[DW-1:HW];
            end else begin
                if (wsel[OFF_DLO] && !busy) dlo_q <= host_wdata;
                if (wsel[OFF_DHI] && !busy) dhi_q <= host_wdata;
            end
            if (wsel[OFF_CTRL]) begin
                stall_q <= host_wdata[0];
                crst_q  <= host_wdata[1];
            end
        end
    end

    always_comb begin
        addr_ext = '0;
        addr_ext[AW-1:0] = addr_q;
    end

    always_comb begin
        host_rdata = '0;
        if (in_win) begin
            unique case (off)
                HAW'(OFF_ADDR): host_rdata = addr_ext;
                HAW'(OFF_DLO):  host_rdata = dlo_q;
                HAW'(OFF_DHI):  host_rdata = dhi_q;
                HAW'(OFF_CMD):  host_rdata[0] = busy;
                default: begin
                    host_rdata[0] = cpu_stalled;
                    host_rdata[1] = crst_q;
                end
            endcase
        end
    end

    assign addr_o  = addr_q;
    assign word_o  = {dhi_q, dlo_q};
    assign stall_o = stall_q;
    assign rst_o   = crst_q;

    p_ctrl_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wsel[OFF_CTRL] |=> (rst_o == $past(host_wdata[1]) && stall_o == $past(host_wdata[0])));
    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wsel[OFF_CTRL] |=> ($stable(rst_o) && $stable(stall_o)));
endmodule

// File: rtl/dbgwin_bridge.sv
`timescale 1ns/1ps
module dbgwin_bridge
    import dbgwin_pkg::*;
#(
    parameter int HAW = 16,
    parameter int HW  = 16,
    parameter int AW  = 16,
    parameter logic [HAW-1:0] BASE = 16'h0200,
    localparam int DW = 2 * HW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_sel,
    input  logic           host_we,
    input  logic [HAW-1:0] host_addr,
    input  logic [HW-1:0]  host_wdata,
    output logic [HW-1:0]  host_rdata,
    output logic           cpu_req,
    output logic           cpu_we,
    output logic [AW-1:0]  cpu_addr,
    output logic [DW-1:0]  cpu_wdata,
    input  logic [DW-1:0]  cpu_rdata,
    input  logic           cpu_ack,
    output logic           cpu_stall,
    output logic           cpu_rst,
    input  logic           cpu_stalled
);
    logic busy, rd_load, start_wr, start_rd;

    dbgwin_regs #(.HAW(HAW), .HW(HW), .AW(AW), .BASE(BASE)) u_regs (
        .clk, .rst_n, .host_sel, .host_we, .host_addr, .host_wdata, .host_rdata,
        .busy, .cpu_stalled, .rd_load, .rd_word(cpu_rdata),
        .start_wr, .start_rd, .addr_o(cpu_addr), .word_o(cpu_wdata),
        .stall_o(cpu_stall), .rst_o(cpu_rst)
    );

    dbgwin_fsm u_fsm (
        .clk, .rst_n, .start_wr, .start_rd, .cpu_ack,
        .cpu_req, .cpu_we, .busy, .rd_load
    );

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ack) |=> (cpu_req && $stable(cpu_we) &&
                                   $stable(cpu_addr) && $stable(cpu_wdata)));
    p_read_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_ack) |=> (cpu_wdata == $past(cpu_rdata)));
endmodule

// File: tb/dbgwin_bridge_test.sv
`timescale 1ns/1ps
module dbgwin_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_we = 1'b0;
    logic [15:0] host_addr = '0, host_wdata = '0, host_rdata;
    logic        cpu_req, cpu_we, cpu_ack = 1'b0, cpu_stall, cpu_rst, cpu_stalled = 1'b0;
    logic [15:0] cpu_addr;
    logic [31:0] cpu_wdata, cpu_rdata = '0;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbgwin_bridge uut (.*);

    // {write, address, data/expected}
    localparam int NV = 11;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 16'h0200, 16'hA5A5},
        {1'b0, 16'h0200, 16'hA5A5},
        {1'b1, 16'h0201, 16'h1111},
        {1'b1, 16'h0202, 16'h2222},
        {1'b0, 16'h0201, 16'h1111},
        {1'b0, 16'h0202, 16'h2222},
        {1'b0, 16'h0203, 16'h0000},
        {1'b1, 16'h0205, 16'hFFFF},
        {1'b0, 16'h0205, 16'h0000},
        {1'b0, 16'h01FF, 16'h0000},
        {1'b0, 16'h0204, 16'h0000}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwr(logic [15:0] a, logic [15:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic hrd(logic [15:0] a, output logic [15:0] d);
        host_addr = a;
        #0.5;
        d = host_rdata;
    endtask

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2", {cpu_req, cpu_stall, cpu_rst}, 0);
        hrd(16'h0203, r); chk("R2", r, 0);
        hrd(16'h0200, r); chk("R2", r, 0);
        rst_n = 1'b1;

        // R1: register window vectors
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][32]) hwr(VEC[i][31:16], VEC[i][15:0]);
            else begin
                @(negedge clk);
                hrd(VEC[i][31:16], r);
                chk("R1", r, VEC[i][15:0]);
            end
        end

        // R3/R5/R7/R10: write transaction held open
        hwr(16'h0200, 16'h1234);
        hwr(16'h0201, 16'hBEEF);
        hwr(16'h0202, 16'hDEAD);
        hwr(16'h0203, 16'h0001);
        chk("R3", {cpu_req, cpu_we}, 2'b11);
        chk("R3", cpu_addr, 16'h1234);
        chk("R3", cpu_wdata, 32'hDEADBEEF);
        hrd(16'h0203, r); chk("R5", r, 1);
        hwr(16'h0200, 16'h5555);
        hwr(16'h0201, 16'h0000);
        hwr(16'h0203, 16'h0002);
        chk("R7", cpu_addr, 16'h1234);
        chk("R7", cpu_wdata, 32'hDEADBEEF);
        chk("R5", {cpu_req, cpu_we}, 2'b11);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R10", cpu_req, 0);
        hrd(16'h0203, r); chk("R5", r, 0);
        @(negedge clk);
        chk("R10", cpu_req, 0);

        // R4/R6: read transaction
        hwr(16'h0200, 16'h0042);
        hwr(16'h0203, 16'h0002);
        chk("R4", {cpu_req, cpu_we}, 2'b10);
        chk("R4", cpu_addr, 16'h0042);
        @(negedge clk);
        cpu_rdata = 32'hCAFEF00D; cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0; cpu_rdata = 32'h0;
        hrd(16'h0201, r); chk("R6", r, 16'hF00D);
        hrd(16'h0202, r); chk("R6", r, 16'hCAFE);
        chk("R10", cpu_req, 0);

        // R4: both command bits select a write
        hwr(16'h0203, 16'h0003);
        chk("R4", {cpu_req, cpu_we}, 2'b11);
        // R8: control accepted while busy
        hwr(16'h0204, 16'h0001);
        chk("R8", {cpu_stall, cpu_rst}, 2'b10);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;

        // R9: readback follows live stalled input
        hrd(16'h0204, r); chk("R9", r, 0);
        cpu_stalled = 1'b1;
        hrd(16'h0204, r); chk("R9", r, 1);
        hwr(16'h0204, 16'h0002);
        chk("R8", {cpu_stall, cpu_rst}, 2'b01);
        repeat (5) @(negedge clk);
        chk("R8", cpu_rst, 1);
        hrd(16'h0204, r); chk("R9", r, 3);
        cpu_stalled = 1'b0;
        hwr(16'h0204, 16'h0000);
        chk("R8", {cpu_stall, cpu_rst}, 2'b00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule